// File: doc/BRIEF.md
# Framed I/Q Sample Word Assembler

This block turns a stream of input slots into aligned pairs of 12-bit two's complement I and Q samples. One slot arrives on every clock. A single framing strobe travels with the data bus. The strobe marks the start of each pair. In one timing mode it also says whether a slot holds I or Q. It also decides whether the datapath is fed real samples or zeros.

There are three slot formats. A full-word slot carries a whole sample. A half-word slot carries six bits on the top of the bus. A quarter-word slot carries three bits on the top of the bus. Narrow formats always deliver the most significant part first, and I before Q. Each finished pair appears on the outputs together with a one-clock valid pulse.

In burst timing, a strobe held low beyond one slot makes the block substitute zeros for the incoming data. Zero pairs keep coming at the normal pair cadence until the strobe rises again. In continuous timing, which is legal only for full-word slots, the strobe level itself tags I (high) and Q (low).

Top module: `iq_frame_asm`

## Requirements
- R1: While reset is asserted, `i_o` and `q_o` are zero, and `valid_o` and `cfg_err_o` are low.
- R2: Full-word format (`fmt_i`=0) in burst timing (`cont_i`=0): slots alternate I then Q. `valid_o` pulses in the clock after each Q slot, with `i_o`/`q_o` set to the two words of that pair.
- R3: Half-word format (`fmt_i`=1): data is taken from `data_i[11:6]`. Four slots build one pair, in the order I[11:6], I[5:0], Q[11:6], Q[5:0].
- R4: Quarter-word format (`fmt_i`=2): data is taken from `data_i[11:9]`. Eight slots build one pair, in the order I[11:9], I[8:6], I[5:3], I[2:0], then the same four chunks for Q.
- R5: In burst timing, a slot where `txen_i` is high after being low in the previous slot is always the first I slot of a new pair. Any partly built pair is abandoned.
- R6: In full-word burst timing, `txen_i` may stay high without limit. It may also drop low for a single Q slot in each pair. Both patterns give the same pairs.
- R7: In burst timing, a slot where `txen_i` is low and was also low in the previous slot contributes zero bits. While the strobe stays low, all-zero pairs are emitted every 2, 4 or 8 clocks, depending on format.
- R8: In continuous timing with `fmt_i`=0, a slot with `txen_i` high is I and a slot with `txen_i` low is Q. Each Q slot emits a pair using the latest I. Zeros are never substituted.
- R9: `cont_i`=1 with a `fmt_i` other than 0, or `fmt_i`=3, is a bad configuration. In that case `cfg_err_o` is high in the following clock and `valid_o` stays low.
- R10: `valid_o` is high only in the clock after a pair completes. `i_o`/`q_o` hold their values in every clock without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock, one slot per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txen_i | input | 1 | Framing strobe |
| data_i | input | 12 | Input slot bus, meaningful bits at the top |
| fmt_i | input | 2 | Slot format: 0 full, 1 half, 2 quarter, 3 reserved |
| cont_i | input | 1 | 1 selects continuous timing, 0 selects burst timing |
| i_o | output | 12 | Assembled I sample |
| q_o | output | 12 | Assembled Q sample |
| valid_o | output | 1 | One-clock pulse per emitted pair |
| cfg_err_o | output | 1 | Bad format/timing combination |

## Verification
The hardest case to reach is a strobe rise that lands in the middle of a narrow-format pair right after a short low gap. That rise must discard the partial word, and it must not be mistaken for the start of zero fill. The stimulus reaches it with quarter- and half-word runs in which the strobe drops for exactly one slot at random positions. These runs are mixed with longer low stretches that cross a whole pair boundary. Every cycle is compared against a bench model that places each chunk at its bit position, rather than shifting it in.

// File: rtl/iq_asm_pkg.sv
package iq_asm_pkg;
  typedef enum logic [1:0] {
    FMT_FULL    = 2'd0,
    FMT_HALF    = 2'd1,
    FMT_QUARTER = 2'd2,
    FMT_RSVD    = 2'd3
  } fmt_e;
endpackage

// File: rtl/iq_slot_ctrl.sv
module iq_slot_ctrl #(
  parameter int SLOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txen_i,
  input  logic              cont_i,
  input  logic [SLOT_W-1:0] last_idx_i,
  input  logic [SLOT_W-1:0] half_cnt_i,
  output logic              is_i_o,
  output logic              last_o,
  output logic              zero_o
);
  logic              txen_q;
  logic [SLOT_W-1:0] slot_q, cur;
  logic              rise;

  assign rise = txen_i & ~txen_q;

  always_comb begin
    if (cont_i)    cur = txen_i ? '0 : SLOT_W'(1);
    else if (rise) cur = '0;
    else           cur = slot_q;
  end

  assign last_o = (cur >= last_idx_i);
  assign is_i_o = (cur < half_cnt_i);
  // second consecutive low slot in burst timing feeds zeros
  assign zero_o = ~cont_i & ~txen_i & ~txen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txen_q <= 1'b0;
      slot_q <= '0;
    end else begin
      txen_q <= txen_i;
      slot_q <= last_o ? '0 : cur + SLOT_W'(1);
    end
  end
endmodule

// File: rtl/iq_word_pack.sv
module iq_word_pack
  import iq_asm_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fmt_e          fmt_i,
  input  logic [DW-1:0] data_i,
  input  logic          zero_i,
  input  logic          is_i_i,
  input  logic          emit_i,
  output logic [DW-1:0] i_o,
  output logic [DW-1:0] q_o,
  output logic          valid_o
);
  localparam int W_HALF = DW / 2;
  localparam int W_QTR  = DW / 4;

  logic [DW-1:0] din, i_sh, q_sh, i_nx, q_nx;

  assign din = zero_i ? '0 : data_i;

  // most significant chunk enters first, so shift left and append
  always_comb begin
    case (fmt_i)
      FMT_HALF: begin
        i_nx = {i_sh[DW-W_HALF-1:0], din[DW-1 -: W_HALF]};
        q_nx = {q_sh[DW-W_HALF-1:0], din[DW-1 -: W_HALF]};
      end
      FMT_QUARTER: begin
        i_nx = {i_sh[DW-W_QTR-1:0], din[DW-1 -: W_QTR]};
        q_nx = {q_sh[DW-W_QTR-1:0], din[DW-1 -: W_QTR]};
      end
      default: begin
        i_nx = din;
        q_nx = din;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_sh    <= '0;
      q_sh    <= '0;
      i_o     <= '0;
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      if (is_i_i) i_sh <= i_nx;
      else        q_sh <= q_nx;
      valid_o <= emit_i;
      if (emit_i) begin
        i_o <= i_sh;
        q_o <= q_nx;
      end
    end
  end
endmodule

// File: rtl/iq_frame_asm.sv
module iq_frame_asm
  import iq_asm_pkg::*;
#(
  parameter int DW        = 12,
  parameter int MAX_SLOTS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          txen_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    fmt_i,
  input  logic          cont_i,
  output logic [DW-1:0] i_o,
  output logic [DW-1:0] q_o,
  output logic          valid_o,
  output logic          cfg_err_o
);
  localparam int SLOT_W = $clog2(MAX_SLOTS);

  fmt_e              fmt;
  logic [SLOT_W-1:0] last_idx, half_cnt;
  logic              is_i, last, zero, bad_cfg, err_q;

  assign fmt     = fmt_e'(fmt_i);
  assign bad_cfg = (fmt == FMT_RSVD) | (cont_i & (fmt != FMT_FULL));

  always_comb begin
    case (fmt)
      FMT_HALF:    begin half_cnt = SLOT_W'(2); last_idx = SLOT_W'(3); end
      FMT_QUARTER: begin half_cnt = SLOT_W'(4); last_idx = SLOT_W'(7); end
      default:     begin half_cnt = SLOT_W'(1); last_idx = SLOT_W'(1); end
    endcase
  end

  iq_slot_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .txen_i     (txen_i),
    .cont_i     (cont_i),
    .last_idx_i (last_idx),
    .half_cnt_i (half_cnt),
    .is_i_o     (is_i),
    .last_o     (last),
    .zero_o     (zero)
  );

  iq_word_pack #(.DW(DW)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fmt_i   (fmt),
    .data_i  (data_i),
    .zero_i  (zero),
    .is_i_i  (is_i),
    .emit_i  (last & ~bad_cfg),
    .i_o     (i_o),
    .q_o     (q_o),
    .valid_o (valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= bad_cfg;
  end
  assign cfg_err_o = err_q;
endmodule

// File: rtl/iq_frame_asm_chk.sv
module iq_frame_asm_chk #(
  parameter int DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          txen_i,
  input logic [1:0]    fmt_i,
  input logic          cont_i,
  input logic [DW-1:0] i_o,
  input logic [DW-1:0] q_o,
  input logic          valid_o,
  input logic          cfg_err_o
);
  logic       prev_txen;
  logic [1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_txen <= 1'b0;
      low_run   <= '0;
    end else begin
      prev_txen <= txen_i;
      if (txen_i)              low_run <= '0;
      else if (low_run != 2'd3) low_run <= low_run + 2'd1;
    end
  end

  p_full_alt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !cont_i && fmt_i == 2'd0 && txen_i && prev_txen) |=> !valid_o);

  p_zero_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_i && fmt_i == 2'd0 && !txen_i && low_run >= 2'd2)
      |=> (!valid_o || (i_o == '0 && q_o == '0)));

  p_cfg_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont_i && fmt_i != 2'd0) |=> cfg_err_o);

  p_err_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> (valid_o || ($stable(i_o) && $stable(q_o))));
endmodule

bind iq_frame_asm iq_frame_asm_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .txen_i    (txen_i),
  .fmt_i     (fmt_i),
  .cont_i    (cont_i),
  .i_o       (i_o),
  .q_o       (q_o),
  .valid_o   (valid_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/iq_frame_asm_test.sv
module iq_frame_asm_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        txen = 1'b0;
  logic [11:0] d = '0;
  logic [1:0]  fmt = 2'd0;
  logic        cont = 1'b0;
  logic [11:0] i_o, q_o;
  logic        valid_o, cfg_err_o;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";

  // bench model state
  bit          m_prev;
  int          m_slot;
  logic [11:0] m_i, m_q, e_i, e_q;
  bit          e_valid, e_err;

  always #10 clk = ~clk;

  iq_frame_asm uut (
    .clk_i(clk), .rst_ni(rst_ni), .txen_i(txen), .data_i(d),
    .fmt_i(fmt), .cont_i(cont), .i_o(i_o), .q_o(q_o),
    .valid_o(valid_o), .cfg_err_o(cfg_err_o)
  );

  task automatic cmp(input string what, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("valid", {11'd0, valid_o}, {11'd0, e_valid});
    cmp("cfg_err", {11'd0, cfg_err_o}, {11'd0, e_err});
    cmp("i", i_o, e_i);
    cmp("q", q_o, e_q);
  endtask

  function automatic int wid(input logic [1:0] f);
    return (f == 2'd1) ? 6 : (f == 2'd2) ? 3 : 12;
  endfunction

  // positional placement model of one clock edge
  task automatic model_step();
    int w, p, s;
    bit rise, z, err, last;
    logic [11:0] ch;
    w    = wid(fmt);
    p    = 12 / w;
    err  = (fmt == 2'd3) || (cont && fmt != 2'd0);
    rise = txen && !m_prev;
    if (cont) s = txen ? 0 : 1;
    else      s = rise ? 0 : m_slot;
    z  = !cont && !txen && !m_prev;
    ch = z ? 12'd0 : (d >> (12 - w));
    for (int b = 0; b < w; b++) begin
      if (s < p) m_i[12 - w*(s+1) + b] = ch[b];
      else       m_q[12 - w*(s-p+1) + b] = ch[b];
    end
    last    = (s >= 2*p - 1);
    e_valid = last && !err;
    if (e_valid) begin
      e_i = m_i;
      e_q = m_q;
    end
    e_err  = err;
    m_slot = last ? 0 : s + 1;
    m_prev = txen;
  endtask

  task automatic cyc(input bit tx, input logic [11:0] dv);
    @(negedge clk);
    check_all();
    txen = tx;
    d    = dv;
    model_step();
  endtask

  task automatic do_reset(input logic [1:0] f, input bit c);
    @(negedge clk);
    check_all();
    rst_ni = 1'b0;
    txen = 1'b0; d = '0; fmt = f; cont = c;
    m_prev = 0; m_slot = 0; m_i = '0; m_q = '0;
    e_i = '0; e_q = '0; e_valid = 0; e_err = 0;
    begin
      string keep = tag;
      tag = "R1";
      repeat (2) begin
        @(negedge clk);
        check_all();
      end
      tag = keep;
    end
    rst_ni = 1'b1;
    model_step();
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd9157));
    m_prev = 0; m_slot = 0; m_i = '0; m_q = '0;
    e_i = '0; e_q = '0; e_valid = 0; e_err = 0;

    tag = "R1"; do_reset(2'd0, 1'b0);

    tag = "R2"; do_reset(2'd0, 1'b0);
    cyc(1, 12'h800); cyc(1, 12'h7FF);
    for (int k = 0; k < 20; k++) cyc(1, 12'($urandom));

    tag = "R6"; do_reset(2'd0, 1'b0);
    for (int k = 0; k < 24; k++) cyc(k[0] ? 1'b0 : 1'b1, 12'($urandom));

    tag = "R3"; do_reset(2'd1, 1'b0);
    cyc(1, 12'hA5F); cyc(1, 12'hC3A); cyc(1, 12'h3F5); cyc(1, 12'h15C);
    for (int k = 0; k < 24; k++) cyc(1, 12'($urandom));

    tag = "R4"; do_reset(2'd2, 1'b0);
    for (int k = 0; k < 8; k++) cyc(1, {k[2:0], 9'h1FF});
    for (int k = 0; k < 32; k++) cyc(1, 12'($urandom));

    tag = "R5";
    for (int f = 1; f <= 2; f++) begin
      do_reset(2'(f), 1'b0);
      for (int k = 0; k < 60; k++) cyc(($urandom_range(0, 5) != 0), 12'($urandom));
    end
    do_reset(2'd2, 1'b0);
    cyc(1, 12'hFFF); cyc(1, 12'hFFF); cyc(1, 12'hFFF);
    cyc(0, 12'hFFF);
    for (int k = 0; k < 8; k++) cyc(1, {k[2:0], 9'h0});

    tag = "R7";
    for (int f = 0; f <= 2; f++) begin
      do_reset(2'(f), 1'b0);
      for (int k = 0; k < 8; k++) cyc(1, 12'($urandom));
      for (int k = 0; k < 20; k++) cyc(0, 12'hFFF);
      for (int k = 0; k < 8; k++) cyc(1, 12'($urandom));
    end

    tag = "R8"; do_reset(2'd0, 1'b1);
    for (int k = 0; k < 20; k++) cyc(k[0] ? 1'b0 : 1'b1, 12'($urandom));
    cyc(1, 12'h123);
    for (int k = 0; k < 6; k++) cyc(0, 12'($urandom) | 12'h001);

    tag = "R9"; do_reset(2'd1, 1'b1);
    for (int k = 0; k < 10; k++) cyc(k[0] ? 1'b0 : 1'b1, 12'($urandom));
    do_reset(2'd3, 1'b0);
    for (int k = 0; k < 10; k++) cyc(1, 12'($urandom));

    tag = "R10";
    for (int r = 0; r < 30; r++) begin
      do_reset(2'($urandom_range(0, 2)), 1'b0);
      for (int k = 0; k < 80; k++) cyc(($urandom_range(0, 3) != 0), 12'($urandom));
    end

    @(negedge clk);
    check_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule